// File: doc/BRIEF.md
# Acquisition Run Control Unit

This block decides when a data-acquisition run is active and which trigger edges count as real triggers. It holds one control word, written and read through a single-cycle register port. The word selects where run start and stop come from: software alone, the level of an external gate input, the first trigger edge after arming, or an auxiliary run input. The auxiliary input can act on its level or on its rising edge.

The gate, auxiliary and trigger inputs are asynchronous. Each passes through a synchronizer before any use. While the run is active and the buffer memory is not full, every rising trigger edge yields a one-cycle qualified trigger pulse.

A trigger counter counts either every trigger edge or only the accepted ones, and it clears whenever a run starts. A board-full flag compares an externally supplied count of occupied buffers against either all buffers or all buffers minus one.

Top module: `acq_run_ctrl`

## Requirements
- R1: With control bits [1:0] = 00 (software mode), `running` equals control bit 2. A write changes `running` on the clock edge after the write edge.
- R2: With bits [1:0] = 01 (gate mode), `running` is 1 only while bit 2 (arm) is 1 and the synchronized gate input is high. When disarmed, the gate input has no effect.
- R3: With bits [1:0] = 10 (first-trigger mode) and arm set, the first synchronized rising trigger edge starts the run and produces no `trig_pulse`. Later edges are qualified triggers. The run ends only when bit 2 is cleared.
- R4: With bits [1:0] = 11 and bit 11 = 0, `running` is 1 only while armed and the synchronized auxiliary run input is high.
- R5: With bits [1:0] = 11 and bit 11 = 1, an armed rising edge of the auxiliary input starts the run. The run then holds, whatever the auxiliary input does, until bit 2 is cleared. After that a fresh rising edge is needed, and a level that was already high at arming does not start it.
- R6: A rising trigger edge seen while `running` = 1 and `board_full` = 0 produces exactly one `trig_pulse` of one cycle. No pulse occurs otherwise.
- R7: With bit 3 = 0, `trig_count` increments once per accepted trigger. With bit 3 = 1, it increments once per trigger rising edge, whether the run is active or the memory is full.
- R8: `trig_count` clears to zero on every transition of `running` from 0 to 1.
- R9: `board_full` is 1 when `bufs_used` >= NUM_BUFS with bit 5 = 0, and when `bufs_used` >= NUM_BUFS-1 with bit 5 = 1.
- R10: Only bits 0, 1, 2, 3, 5 and 11 are stored. `reg_rdata` returns them in place and zero in every other bit. Writing all ones reads back 0x0000082F.
- R11: While `rst` is high and after its release, the control word reads 0. `running`, `trig_pulse` and `trig_count` are 0, and `board_full` follows only `bufs_used`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data |
| reg_rdata | output | 32 | Control word read data |
| gate_in | input | 1 | Asynchronous external gate input |
| aux_run_in | input | 1 | Asynchronous auxiliary run input |
| trig_in | input | 1 | Asynchronous trigger input |
| bufs_used | input | BUF_W | Number of occupied buffers |
| running | output | 1 | Run active flag |
| trig_pulse | output | 1 | One-cycle qualified trigger pulse |
| trig_count | output | CNT_W | Trigger counter |
| board_full | output | 1 | Buffer memory full flag |

## Verification
A wrong run state shows at `running` within one cycle of the cause. In first-trigger mode it shows one cycle late or early as a spurious or missing `trig_pulse` on the starting edge. A stuck edge-mode latch shows as `running` dropping when the auxiliary input falls, or as a run that restarts with no new edge after re-arming. A corrupted counter or clear path shows in `trig_count` right after the pulse sequence that should have moved it, so each trigger pattern is checked through the pulse tally and the counter together.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        SRC_SOFT  = 2'b00,
        SRC_GATE  = 2'b01,
        SRC_FIRST = 2'b10,
        SRC_AUX   = 2'b11
    } run_src_e;

    typedef struct packed {
        logic     aux_edge;
        logic     full_less_one;
        logic     count_all;
        logic     arm;
        run_src_e src;
    } acq_cfg_t;

    localparam int WORD_W        = 32;
    localparam int BIT_ARM       = 2;
    localparam int BIT_COUNT_ALL = 3;
    localparam int BIT_FULL_LESS = 5;
    localparam int BIT_AUX_EDGE  = 11;

    function automatic acq_cfg_t cfg_from_word(input logic [WORD_W-1:0] w);
        acq_cfg_t c;
        c.src           = run_src_e'(w[1:0]);
        c.arm           = w[BIT_ARM];
        c.count_all     = w[BIT_COUNT_ALL];
        c.full_less_one = w[BIT_FULL_LESS];
        c.aux_edge      = w[BIT_AUX_EDGE];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_to_word(input acq_cfg_t c);
        logic [WORD_W-1:0] w;
        w                = '0;
        w[1:0]           = c.src;
        w[BIT_ARM]       = c.arm;
        w[BIT_COUNT_ALL] = c.count_all;
        w[BIT_FULL_LESS] = c.full_less_one;
        w[BIT_AUX_EDGE]  = c.aux_edge;
        return w;
    endfunction

endpackage

// File: rtl/acq_sync.sv
module acq_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] level,
    output logic [W-1:0] rise
);
    logic [W-1:0] chain [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
            prev <= '0;
        end else begin
            chain[0] <= din;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            prev <= chain[STAGES-1];
        end
    end

    assign level = chain[STAGES-1];
    assign rise  = level & ~prev;

    // A rising edge is reported only against a previously low sample
    p_rise_single_r6: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/acq_cfg_reg.sv
module acq_cfg_reg
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output acq_cfg_t          cfg
);
    always_ff @(posedge clk) begin
        if (rst) cfg <= cfg_from_word('0);
        else if (wr) cfg <= cfg_from_word(wdata);
    end

    assign rdata = cfg_to_word(cfg);

    p_write_lands_r10: assert property (@(posedge clk) disable iff (rst)
        wr |=> (rdata == ($past(wdata) & 32'h0000_082F)));
endmodule

// File: rtl/acq_run_sel.sv
module acq_run_sel
    import acq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  acq_cfg_t cfg,
    input  logic     gate_lvl,
    input  logic     aux_lvl,
    input  logic     aux_rise,
    input  logic     trig_rise,
    output logic     running,
    output logic     start
);
    logic run_nx;

    always_comb begin
        run_nx = 1'b0;
        unique case (cfg.src)
            SRC_SOFT:  run_nx = cfg.arm;
            SRC_GATE:  run_nx = cfg.arm & gate_lvl;
            SRC_FIRST: run_nx = cfg.arm & (running | trig_rise);
            SRC_AUX: begin
                if (cfg.aux_edge) run_nx = cfg.arm & (running | aux_rise);
                else              run_nx = cfg.arm & aux_lvl;
            end
            default:   run_nx = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) running <= 1'b0;
        else     running <= run_nx;
    end

    assign start = run_nx & ~running;

    p_soft_follow_r1: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_SOFT) |=> (running == $past(cfg.arm)));
    p_gate_low_off_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_GATE && !gate_lvl) |=> !running);
    p_first_holds_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_FIRST && cfg.arm && running) |=> running);
    p_aux_level_r4: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_AUX && !cfg.aux_edge && !aux_lvl) |=> !running);
    p_aux_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (cfg.src == SRC_AUX && cfg.aux_edge && cfg.arm && running) |=> running);
    p_disarm_off_r3: assert property (@(posedge clk) disable iff (rst)
        !cfg.arm |=> !running);
endmodule

// File: rtl/acq_trig_unit.sv
module acq_trig_unit
    import acq_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NUM_BUFS = 16,
    parameter int BUF_W    = $clog2(NUM_BUFS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  acq_cfg_t         cfg,
    input  logic             running,
    input  logic             start,
    input  logic             trig_rise,
    input  logic [BUF_W-1:0] bufs_used,
    output logic             trig_pulse,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    localparam logic [BUF_W-1:0] LIM_ALL  = BUF_W'(NUM_BUFS);
    localparam logic [BUF_W-1:0] LIM_LESS = BUF_W'(NUM_BUFS - 1);

    logic accept;
    logic bump;

    assign full   = bufs_used >= (cfg.full_less_one ? LIM_LESS : LIM_ALL);
    assign accept = trig_rise & running & ~full;
    assign bump   = cfg.count_all ? trig_rise : accept;

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_pulse <= 1'b0;
            count      <= '0;
        end else begin
            trig_pulse <= accept;
            if (start)     count <= '0;
            else if (bump) count <= count + 1'b1;
        end
    end

    p_pulse_needs_run_r6: assert property (@(posedge clk) disable iff (rst)
        trig_pulse |-> $past(running) && !$past(full));
    p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
        !start |=> (count == $past(count) || count == $past(count) + 1'b1));
    p_start_clears_r8: assert property (@(posedge clk) disable iff (rst)
        start |=> (count == '0));
    p_full_all_r9: assert property (@(posedge clk) disable iff (rst)
        (bufs_used >= LIM_ALL) |-> full);
    p_full_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (bufs_used < LIM_LESS) |-> !full);
endmodule

// File: rtl/acq_run_ctrl.sv
module acq_run_ctrl
    import acq_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int NUM_BUFS    = 16,
    parameter int SYNC_STAGES = 2,
    parameter int BUF_W       = $clog2(NUM_BUFS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             gate_in,
    input  logic             aux_run_in,
    input  logic             trig_in,
    input  logic [BUF_W-1:0] bufs_used,
    output logic             running,
    output logic             trig_pulse,
    output logic [CNT_W-1:0] trig_count,
    output logic             board_full
);
    localparam int N_IN = 3;
    localparam int I_GATE = 0;
    localparam int I_AUX  = 1;
    localparam int I_TRIG = 2;

    acq_cfg_t        cfg;
    logic [N_IN-1:0] lvl;
    logic [N_IN-1:0] rise;
    logic            start;

    acq_cfg_reg u_reg (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    acq_sync #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .din   ({trig_in, aux_run_in, gate_in}),
        .level (lvl),
        .rise  (rise)
    );

    acq_run_sel u_run (
        .clk       (clk),
        .rst       (rst),
        .cfg       (cfg),
        .gate_lvl  (lvl[I_GATE]),
        .aux_lvl   (lvl[I_AUX]),
        .aux_rise  (rise[I_AUX]),
        .trig_rise (rise[I_TRIG]),
        .running   (running),
        .start     (start)
    );

    acq_trig_unit #(.CNT_W(CNT_W), .NUM_BUFS(NUM_BUFS), .BUF_W(BUF_W)) u_trig (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .running    (running),
        .start      (start),
        .trig_rise  (rise[I_TRIG]),
        .bufs_used  (bufs_used),
        .trig_pulse (trig_pulse),
        .count      (trig_count),
        .full       (board_full)
    );

    p_reset_quiet_r11: assert property (@(posedge clk)
        rst |=> (!running && !trig_pulse && trig_count == '0 && reg_rdata == '0));
endmodule

// File: tb/sim_acq_run_ctrl.sv
module sim_acq_run_ctrl;
    localparam int NB  = 16;
    localparam int BW  = $clog2(NB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr = 1'b0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          gate_in = 1'b0;
    logic          aux_run_in = 1'b0;
    logic          trig_in = 1'b0;
    logic [BW-1:0] bufs_used = '0;
    logic          running;
    logic          trig_pulse;
    logic [31:0]   trig_count;
    logic          board_full;

    int n_chk = 0;
    int n_bad = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acq_run_ctrl #(.CNT_W(32), .NUM_BUFS(NB)) u0 (.*);

    always @(negedge clk) if (!rst && trig_pulse) pulses++;

    typedef struct packed {
        logic [31:0] ctrl;
        logic        gate;
        logic        aux;
        logic        exp_run;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{32'h0000_0000, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0004, 1'b0, 1'b0, 1'b1},
        '{32'h0000_0001, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0005, 1'b0, 1'b1, 1'b0},
        '{32'h0000_0005, 1'b1, 1'b0, 1'b1},
        '{32'h0000_0007, 1'b1, 1'b0, 1'b0},
        '{32'h0000_0007, 1'b0, 1'b1, 1'b1},
        '{32'h0000_0003, 1'b1, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic trig_once();
        @(negedge clk);
        trig_in = 1'b1;
        wait_n(4);
        trig_in = 1'b0;
        wait_n(4);
    endtask

    function automatic string vtag(input logic [1:0] m);
        case (m)
            2'b00:   return "R1 soft";
            2'b01:   return "R2 gate";
            default: return "R4 aux level";
        endcase
    endfunction

    initial begin
        int p0;
        logic [31:0] c0;
        wait_n(3);
        chk("R11 rdata in reset", reg_rdata, 0);
        chk("R11 running in reset", running, 0);
        rst = 1'b0;
        wait_n(2);
        chk("R11 running after reset", running, 0);
        chk("R11 count after reset", trig_count, 0);
        chk("R11 full after reset", board_full, 0);

        // R1 latency: running follows one edge after the write edge
        wr(32'h4);
        chk("R1 not yet running", running, 0);
        @(negedge clk);
        chk("R1 running one edge later", running, 1);
        wr(32'h0);
        wait_n(2);

        // R10 readback
        wr(32'hFFFF_FFFF);
        chk("R10 reserved bits read zero", reg_rdata, 32'h0000_082F);
        wr(32'h0);
        wait_n(2);

        foreach (VEC[i]) begin
            gate_in = VEC[i].gate;
            aux_run_in = VEC[i].aux;
            wr(VEC[i].ctrl);
            wait_n(6);
            chk(vtag(VEC[i].ctrl[1:0]), running, VEC[i].exp_run);
        end
        gate_in = 1'b0;
        aux_run_in = 1'b0;
        wr(32'h0);
        wait_n(4);

        // R3 first trigger mode
        wr(32'h6);
        wait_n(3);
        chk("R3 armed not running", running, 0);
        p0 = pulses;
        trig_once();
        chk("R3 first edge starts run", running, 1);
        chk("R3 first edge no pulse", pulses - p0, 0);
        chk("R8 count clear at start", trig_count, 0);
        trig_once();
        chk("R6 second edge one pulse", pulses - p0, 1);
        chk("R7 accepted count", trig_count, 1);
        trig_once();
        chk("R7 accepted count two", trig_count, 2);
        wait_n(10);
        chk("R3 stays running", running, 1);
        wr(32'h2);
        wait_n(2);
        chk("R3 clears on disarm", running, 0);

        // R7 count all while stopped
        wr(32'h8);
        wait_n(2);
        c0 = trig_count;
        p0 = pulses;
        trig_once();
        trig_once();
        chk("R7 count-all while stopped", trig_count, c0 + 2);
        chk("R6 no pulse while stopped", pulses - p0, 0);

        // R8 start clears, accepted-only counting
        wr(32'h4);
        wait_n(2);
        chk("R8 clear on run start", trig_count, 0);
        trig_once();
        chk("R6 pulse while running", pulses - p0, 1);
        chk("R7 count accepted", trig_count, 1);

        // R9 full thresholds
        bufs_used = BW'(NB - 1);
        wait_n(1);
        chk("R9 Nb-1 not full when mode 0", board_full, 0);
        wr(32'h24);
        wait_n(1);
        chk("R9 Nb-1 full when mode 1", board_full, 1);
        p0 = pulses;
        c0 = trig_count;
        trig_once();
        chk("R6 no pulse when full", pulses - p0, 0);
        chk("R7 accepted-only ignores full edge", trig_count, c0);
        wr(32'h2C);
        trig_once();
        chk("R7 count-all counts full edge", trig_count, c0 + 1);
        chk("R6 still no pulse when full", pulses - p0, 0);
        wr(32'h4);
        bufs_used = BW'(NB);
        wait_n(1);
        chk("R9 Nb full when mode 0", board_full, 1);
        bufs_used = '0;
        wr(32'h0);
        wait_n(2);

        // R5 aux edge mode
        aux_run_in = 1'b1;
        wait_n(4);
        wr(32'h807);
        wait_n(4);
        chk("R5 high level at arm no start", running, 0);
        aux_run_in = 1'b0;
        wait_n(4);
        aux_run_in = 1'b1;
        wait_n(4);
        chk("R5 rising edge starts", running, 1);
        aux_run_in = 1'b0;
        wait_n(6);
        chk("R5 holds after input falls", running, 1);
        wr(32'h803);
        wait_n(2);
        chk("R5 disarm stops", running, 0);
        wr(32'h807);
        wait_n(6);
        chk("R5 re-arm needs new edge", running, 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule